// File: doc/BRIEF.md
# Protection Error Capture Unit

This block is the reporting and control section of a memory protection unit that serves four bus ports. The access checker sends it an error pulse for each port, with the 32-bit faulting address and an attribute word. When an error arrives while the unit is enabled, the block stores the address and the attributes in that port's read-only registers and sets that port's pending flag. Software reads the stored values over a simple register bus and clears a flag by writing a one to its bit.

Each port has a small two-state machine. `SLOT_IDLE` means that nothing unread is held. `SLOT_HELD` means that an unread error is stored. The transitions are:
- capture: `SLOT_IDLE` to `SLOT_HELD` on an error.
- overwrite: `SLOT_HELD` to `SLOT_HELD` on an error.
- clear: `SLOT_HELD` to `SLOT_IDLE` on a write-one with no error in the same cycle.
- keep: stay in the current state in all other cases.

The control word also holds a global enable bit, which drives the checker's enable output. It also holds fixed identification codes.

Register map (byte addresses, 32-bit words):
- `0x00`: control word.
- `0x10 + 8*n`: address of port n.
- `0x14 + 8*n`: attributes of port n.

Control word fields:
- `[3:0]`: pending flags, write-one-to-clear.
- `[11:8]`: port-count code.
- `[15:12]`: revision.
- `[19:16]`: region-count code.
- `[31]`: enable.
- All other bits read as 0.

Top module: `pecu_top`

## Requirements
- R1: After reset, the enable bit and output are 0. All flags are 0. Every address and attribute register reads 0.
- R2: An error pulse on port n while the unit is enabled has the following effects at the next clock edge. The 32-bit address is stored in the register at 0x10+8n. The attribute word is stored at 0x14+8n. Bit n of the control word's `[3:0]` field is set.
- R3: In cycles with no error on a port, that port's address and attribute registers keep their values.
- R4: A write to 0x00 with a one in flag bit n clears flag n. A zero in that bit leaves the flag unchanged. Clearing a flag does not change the stored address or attributes.
- R5: If an error on port n arrives in the same cycle as a write-one to flag n, the flag stays set and the new values are stored.
- R6: A later error on a port whose flag is set overwrites the stored values, and the flag stays 1.
- R7: A write to 0x00 loads bit 31 into the enable bit, which drives `mpu_enable_o` from the next cycle. While the enable bit is 0, error pulses are ignored.
- R8: The ID fields read as fixed codes: revision `[15:12]`=0, port code `[11:8]`=3 (port count minus one), region code `[19:16]`=2 for 16 regions (0 for 8).
- R9: Writes to the address and attribute registers, and to the ID bits of the control word, do not change what those locations read.
- R10: Reads of addresses that are not mapped return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| err_pulse_i | input | 4 | One error strobe per port |
| err_addr_i | input | 128 | Faulting address per port, port n at bits [32n+31:32n] |
| err_attr_i | input | 128 | Attribute word per port, port n at bits [32n+31:32n] |
| bus_sel_i | input | 1 | Register bus select |
| bus_wr_i | input | 1 | Write strobe, valid with select |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| mpu_enable_o | output | 1 | Global enable sent to the access checker |

## Verification
Two functions can fall in the same cycle: an error capture and a write-one clear of the same flag. The bench creates this collision by asserting a port's error pulse in the same cycle as a control-word write that carries that port's flag bit. The flag must still read 1 afterwards, with the new address and attributes stored. The bench also makes a capture and an enable write coincide, and checks that the gate uses the enable value from before the write.

// File: rtl/pecu_pkg.sv
package pecu_pkg;
    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_HELD = 1'b1
    } slot_state_e;

    localparam logic [7:0] CTRL_OFS  = 8'h00;
    localparam logic [7:0] PORT_BASE = 8'h10;
    localparam int         PORT_STEP = 8;

    function automatic logic [3:0] region_code(input int regions);
        return (regions == 16) ? 4'b0010 : 4'b0000;
    endfunction
endpackage

// File: rtl/pecu_slot.sv
module pecu_slot
    import pecu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ATTR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic              clear_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ATTR_W-1:0] attr_i,
    output logic              flag_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ATTR_W-1:0] attr_o
);
    slot_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_IDLE: if (take_i) state_d = SLOT_HELD;
            SLOT_HELD: begin
                if (take_i)       state_d = SLOT_HELD;
                else if (clear_i) state_d = SLOT_IDLE;
            end
            default: state_d = SLOT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_o <= '0;
            attr_o <= '0;
        end else if (take_i) begin
            addr_o <= addr_i;
            attr_o <= attr_i;
        end
    end

    assign flag_o = (state_q == SLOT_HELD);

    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> (flag_o && addr_o == $past(addr_i) && attr_o == $past(attr_i)));
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> ($stable(addr_o) && $stable(attr_o)));
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !take_i) |=> !flag_o);
    p_collide_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && take_i) |=> flag_o);
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clear_i) |=> flag_o);
endmodule

// File: rtl/pecu_csr.sv
module pecu_csr
    import pecu_pkg::*;
#(
    parameter int NUM_PORTS   = 4,
    parameter int ADDR_W      = 32,
    parameter int ATTR_W      = 32,
    parameter int NUM_REGIONS = 16,
    parameter int REVISION    = 0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_sel_i,
    input  logic                          bus_wr_i,
    input  logic [7:0]                    bus_addr_i,
    input  logic [31:0]                   bus_wdata_i,
    input  logic [NUM_PORTS-1:0]          flags_i,
    input  logic [NUM_PORTS*ADDR_W-1:0]   addr_flat_i,
    input  logic [NUM_PORTS*ATTR_W-1:0]   attr_flat_i,
    output logic                          enable_o,
    output logic [NUM_PORTS-1:0]          clear_o,
    output logic [31:0]                   bus_rdata_o
);
    localparam logic [3:0] PORT_CODE = 4'(NUM_PORTS - 1);
    localparam logic [3:0] REGN_CODE = region_code(NUM_REGIONS);
    localparam logic [3:0] REV_CODE  = 4'(REVISION);

    logic ctrl_wr;
    assign ctrl_wr = bus_sel_i && bus_wr_i && (bus_addr_i == CTRL_OFS);
    assign clear_o = ctrl_wr ? bus_wdata_i[NUM_PORTS-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       enable_o <= 1'b0;
        else if (ctrl_wr) enable_o <= bus_wdata_i[31];
    end

    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == CTRL_OFS) begin
            bus_rdata_o[NUM_PORTS-1:0] = flags_i;
            bus_rdata_o[11:8]          = PORT_CODE;
            bus_rdata_o[15:12]         = REV_CODE;
            bus_rdata_o[19:16]         = REGN_CODE;
            bus_rdata_o[31]            = enable_o;
        end
        for (int n = 0; n < NUM_PORTS; n++) begin
            if (bus_addr_i == 8'(PORT_BASE + PORT_STEP * n))
                bus_rdata_o = 32'(addr_flat_i[n*ADDR_W +: ADDR_W]);
            if (bus_addr_i == 8'(PORT_BASE + PORT_STEP * n + 4))
                bus_rdata_o = 32'(attr_flat_i[n*ATTR_W +: ATTR_W]);
        end
    end

    p_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (enable_o == $past(bus_wdata_i[31])));
    p_enable_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(enable_o));
endmodule

// File: rtl/pecu_top.sv
module pecu_top #(
    parameter int NUM_PORTS   = 4,
    parameter int ADDR_W      = 32,
    parameter int ATTR_W      = 32,
    parameter int NUM_REGIONS = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PORTS-1:0]        err_pulse_i,
    input  logic [NUM_PORTS*ADDR_W-1:0] err_addr_i,
    input  logic [NUM_PORTS*ATTR_W-1:0] err_attr_i,
    input  logic                        bus_sel_i,
    input  logic                        bus_wr_i,
    input  logic [7:0]                  bus_addr_i,
    input  logic [31:0]                 bus_wdata_i,
    output logic [31:0]                 bus_rdata_o,
    output logic                        mpu_enable_o
);
    logic [NUM_PORTS-1:0]        take, clear, flags;
    logic [NUM_PORTS*ADDR_W-1:0] addr_flat;
    logic [NUM_PORTS*ATTR_W-1:0] attr_flat;

    assign take = err_pulse_i & {NUM_PORTS{mpu_enable_o}};

    for (genvar n = 0; n < NUM_PORTS; n++) begin : g_slot
        pecu_slot #(.ADDR_W(ADDR_W), .ATTR_W(ATTR_W)) i_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .take_i  (take[n]),
            .clear_i (clear[n]),
            .addr_i  (err_addr_i[n*ADDR_W +: ADDR_W]),
            .attr_i  (err_attr_i[n*ATTR_W +: ATTR_W]),
            .flag_o  (flags[n]),
            .addr_o  (addr_flat[n*ADDR_W +: ADDR_W]),
            .attr_o  (attr_flat[n*ATTR_W +: ATTR_W])
        );
    end

    pecu_csr #(
        .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .ATTR_W(ATTR_W),
        .NUM_REGIONS(NUM_REGIONS), .REVISION(0)
    ) i_csr (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel_i   (bus_sel_i),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .flags_i     (flags),
        .addr_flat_i (addr_flat),
        .attr_flat_i (attr_flat),
        .enable_o    (mpu_enable_o),
        .clear_o     (clear),
        .bus_rdata_o (bus_rdata_o)
    );

    p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mpu_enable_o && flags == '0) |=> (flags == '0));
    p_flag_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take != '0) |=> ((flags & $past(take)) == $past(take)));
endmodule

// File: tb/test_pecu_top.sv
module test_pecu_top;
    localparam time PERIOD = 10ns;
    localparam int  NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] err_pulse = '0;
    logic [NP*32-1:0] err_addr = '0, err_attr = '0;
    logic          bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0, bus_rdata;
    logic          mpu_enable;

    int checks = 0, fails = 0;
    bit done = 0;

    // reference model
    bit          m_en;
    bit [NP-1:0] m_flag;
    bit [31:0]   m_addr [NP];
    bit [31:0]   m_attr [NP];

    always #(PERIOD/2) clk = ~clk;

    pecu_top i_pecu_top (
        .clk(clk), .rst_n(rst_n), .err_pulse_i(err_pulse), .err_addr_i(err_addr),
        .err_attr_i(err_attr), .bus_sel_i(bus_sel), .bus_wr_i(bus_wr),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .mpu_enable_o(mpu_enable)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en <= 0; m_flag <= '0;
            for (int n = 0; n < NP; n++) begin m_addr[n] <= 0; m_attr[n] <= 0; end
        end else begin
            bit wr0;
            wr0 = bus_sel && bus_wr && bus_addr == 8'h00;
            for (int n = 0; n < NP; n++) begin
                if (err_pulse[n] && m_en) begin
                    m_flag[n] <= 1;
                    m_addr[n] <= err_addr[n*32 +: 32];
                    m_attr[n] <= err_attr[n*32 +: 32];
                end else if (wr0 && bus_wdata[n]) m_flag[n] <= 0;
            end
            if (wr0) m_en <= bus_wdata[31];
        end
    end

    function automatic logic [31:0] model_read(input logic [7:0] a);
        if (a == 8'h00) return {m_en, 11'd0, 4'd2, 4'd0, 4'd3, 4'd0, 4'(m_flag)};
        for (int n = 0; n < NP; n++) begin
            if (a == 8'(8'h10 + 8*n)) return m_addr[n];
            if (a == 8'(8'h14 + 8*n)) return m_attr[n];
        end
        return 0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // compare enable output on every clock
    always @(negedge clk) if (rst_n && !done) check("R7", {31'd0, mpu_enable}, {31'd0, m_en});

    task automatic rd(input logic [7:0] a, input string req);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 check(req, bus_rdata, model_read(a));
        bus_sel = 0;
    endtask

    task automatic sweep(input string req);
        rd(8'h00, req);
        for (int n = 0; n < NP; n++) begin
            rd(8'(8'h10 + 8*n), req);
            rd(8'(8'h14 + 8*n), req);
        end
    endtask

    // one cycle of stimulus: error mask plus optional bus write
    task automatic cyc(input logic [NP-1:0] err, input logic [31:0] base,
                       input bit wr, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        err_pulse = err;
        for (int n = 0; n < NP; n++) begin
            err_addr[n*32 +: 32] = base + 32'(n * 32'h100);
            err_attr[n*32 +: 32] = ~base ^ 32'(n);
        end
        bus_sel = wr; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        err_pulse = '0; bus_sel = 0; bus_wr = 0;
    endtask

    initial begin
        #(PERIOD * 50000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 3) rst_n = 1;
        // R1 reset state, R8 ID codes
        sweep("R1");
        check("R8", model_read(8'h00) & 32'h000F_FF00, 32'h0002_0300);
        rd(8'h00, "R8");
        // R7 disabled: error ignored
        cyc(4'b1111, 32'hDEAD_0000, 0, 8'h00, 0);
        sweep("R7");
        check("R7", bus_rdata, 32'h0);
        // enable
        cyc(4'b0000, 0, 1, 8'h00, 32'h8000_0000);
        rd(8'h00, "R7");
        // R2 capture on port 2, then ports 0 and 3
        cyc(4'b0100, 32'h1000_0000, 0, 0, 0);
        sweep("R2");
        cyc(4'b1001, 32'h2000_0000, 0, 0, 0);
        sweep("R2");
        // R3 hold across idle cycles
        repeat (5) @(negedge clk);
        sweep("R3");
        // R6 overwrite port 2
        cyc(4'b0100, 32'h3000_0000, 0, 0, 0);
        sweep("R6");
        // R4 writing zeros: no effect; then clear bit2
        cyc(4'b0000, 0, 1, 8'h00, 32'h8000_0000);
        sweep("R4");
        cyc(4'b0000, 0, 1, 8'h00, 32'h8000_0004);
        sweep("R4");
        // R5 collision on port 0; clear port 3 simultaneously without error
        cyc(4'b0001, 32'h4000_0000, 1, 8'h00, 32'h8000_0009);
        sweep("R5");
        // R9 writes to read-only regs and ID bits
        cyc(4'b0000, 0, 1, 8'h10, 32'hFFFF_FFFF);
        cyc(4'b0000, 0, 1, 8'h24, 32'h1234_5678);
        cyc(4'b0000, 0, 1, 8'h00, 32'hFFFF_FFF0);
        sweep("R9");
        // R10 unmapped reads
        rd(8'h08, "R10");
        rd(8'h40, "R10");
        rd(8'h13, "R10");
        // R7 disable together with an error: old enable still gates
        cyc(4'b0010, 32'h5000_0000, 1, 8'h00, 32'h0000_0000);
        sweep("R7");
        cyc(4'b1000, 32'h6000_0000, 0, 0, 0);
        sweep("R7");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule